// File: doc/BRIEF.md
# Fractional Baud-Rate Generator

This block derives the timing references of a serial port from the system clock. The divisor has a 16-bit whole part and a 6-bit fraction counted in sixty-fourths. The oversample tick `os_tick` comes once per divisor period, so its average period is `I + F/64` system clocks. The divisor is the system clock divided by (k × baud rate), where k is 16 in normal mode and 8 when `hs_sel` is high. A second pulse, `bit_tick`, marks one baud period: one pulse for every 16 oversample ticks, or every 8 in high-speed mode.

Software loads the divisor through two staging registers, one for the whole part and one for the fraction. The divisor parts may be written in any order, and one part may be left as it was. Nothing reaches the divider until the line-control byte is written. That write copies the staged whole part, the staged fraction and the new line-control byte into one 30-bit active register, and it restarts the divider. The active line-control byte is passed on at `line_ctrl` for the framing logic.

The register pins are plain write strobes with data, one cycle per write. There is no stream interface and no back-pressure: every strobe is taken in the cycle it is high.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, `line_ctrl` is 0 and the active whole divisor is 0, so neither tick pulses until a line-control write.
- R2: Writes to the whole-part or fraction staging register alone leave the tick timing and `line_ctrl` unchanged.
- R3: A line-control write with `lcr_wr` high at edge E updates the 30-bit active register at E. From then on `line_ctrl` shows that byte, and the divider uses the values staged before E.
- R4: Staging the fraction first and the whole part second gives the same active divisor as the reverse order.
- R5: A staging register that is not written keeps its value, so a commit after writing only one part reuses the other part's earlier value.
- R6: With whole part I ≥ 1 and fraction F, every interval between `os_tick` pulses is I or I+1 clocks, and any 64 consecutive intervals total 64·I+F clocks.
- R7: With F = 0, every `os_tick` interval is exactly I clocks.
- R8: With an active whole part of 0, `os_tick` and `bit_tick` stay low.
- R9: `bit_tick` pulses once every 16 `os_tick` pulses when `hs_sel` is 0, and once every 8 when `hs_sel` is 1.
- R10: A commit restarts the divider. For a commit at edge E, `os_tick` is low after edge E+1 and is first high after edge E+I+1.
- R11: `os_tick` is a single-cycle pulse whenever I > 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_sel | input | 1 | 1 selects 8× oversampling, 0 selects 16× |
| int_wr | input | 1 | Write strobe for the whole-part staging register |
| int_din | input | 16 | Whole part of the divisor |
| frac_wr | input | 1 | Write strobe for the fraction staging register |
| frac_din | input | 6 | Fraction of the divisor, in 1/64 units |
| lcr_wr | input | 1 | Line-control write; commits the whole active register |
| lcr_din | input | 8 | Line-control byte |
| os_tick | output | 1 | Oversample reference pulse |
| bit_tick | output | 1 | Baud-period pulse |
| line_ctrl | output | 8 | Active line-control byte |

## Verification
The divider is run with several divisors. A pure whole number (3) shows that the intervals are even. Fractions of 16, 8 and 40 show the mix of long and short intervals and whether the 64-interval total has drifted. A whole part of 1 tests the shortest possible period, and a zero whole part checks that the divider is off. Commits are made in both staging orders and with only one part written. Staged-only writes are observed at the ports to show they do not affect the output. The interval from a commit to the first tick is counted, and `bit_tick` spacing is measured in both oversampling modes.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  parameter int DIV_INT_W  = 16;
  parameter int DIV_FRAC_W = 6;
  parameter int LINE_W     = 8;
  parameter int OSR_LOG2   = 4;
  localparam int ACTIVE_W  = DIV_INT_W + DIV_FRAC_W + LINE_W;

  typedef struct packed {
    logic [LINE_W-1:0]     line;
    logic [DIV_INT_W-1:0]  whole;
    logic [DIV_FRAC_W-1:0] frac;
  } baud_active_t;
endpackage

// File: rtl/baud_stage_regs.sv
module baud_stage_regs
  import frac_baud_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  int_wr,
  input  logic [DIV_INT_W-1:0]  int_din,
  input  logic                  frac_wr,
  input  logic [DIV_FRAC_W-1:0] frac_din,
  input  logic                  lcr_wr,
  input  logic [LINE_W-1:0]     lcr_din,
  output baud_active_t          active,
  output logic                  commit
);
  logic [DIV_INT_W-1:0]  stg_whole;
  logic [DIV_FRAC_W-1:0] stg_frac;

  // staging registers: hold until rewritten
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_whole <= '0;
      stg_frac  <= '0;
    end else begin
      if (int_wr)  stg_whole <= int_din;
      if (frac_wr) stg_frac  <= frac_din;
    end
  end

  // active register: written only by a line-control write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
      commit <= 1'b0;
    end else begin
      commit <= lcr_wr;
      if (lcr_wr) begin
        active.line  <= lcr_din;
        active.whole <= stg_whole;
        active.frac  <= stg_frac;
      end
    end
  end

  // R2: without a line-control write the active register holds
  a_r2_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr |=> $stable(active));
  // R3: a commit takes the staged values from before the write cycle
  a_r3_commit_takes_stage: assert property (@(posedge clk) disable iff (!rst_n)
    lcr_wr |=> (active.line == $past(lcr_din)) && (active.whole == $past(stg_whole))
               && (active.frac == $past(stg_frac)));
  // R5: an unwritten staging register keeps its value
  a_r5_stage_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !int_wr |=> $stable(stg_whole));
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic [INT_W-1:0]  div_whole,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              os_tick
);
  logic [INT_W-1:0]  cnt;
  logic [FRAC_W-1:0] phase;
  logic [FRAC_W:0]   phase_sum;
  logic              running;
  logic [INT_W-1:0]  next_len;

  assign running   = (div_whole != '0);
  assign phase_sum = {1'b0, phase} + {1'b0, div_frac};
  // a phase carry lengthens the coming period by one clock
  assign next_len  = div_whole - INT_W'(1) + INT_W'(phase_sum[FRAC_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      phase   <= '0;
      os_tick <= 1'b0;
    end else if (reload) begin
      cnt     <= div_whole - INT_W'(1);
      phase   <= '0;
      os_tick <= 1'b0;
    end else if (!running) begin
      cnt     <= '0;
      phase   <= '0;
      os_tick <= 1'b0;
    end else if (cnt == '0) begin
      os_tick <= 1'b1;
      phase   <= phase_sum[FRAC_W-1:0];
      cnt     <= next_len;
    end else begin
      os_tick <= 1'b0;
      cnt     <= cnt - INT_W'(1);
    end
  end

  // R8: a zero whole part produces no tick
  a_r8_no_tick_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (div_whole == '0) |=> !os_tick);
  // R10: the cycle after a reload carries no tick
  a_r10_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !os_tick);
  // R11: ticks are single-cycle when the whole part exceeds one
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && div_whole > INT_W'(1) && !reload) |=> !os_tick);
endmodule

// File: rtl/baud_bit_prescale.sv
module baud_bit_prescale #(
  parameter int OSR_LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic hs_sel,
  input  logic os_tick,
  output logic bit_tick
);
  localparam logic [OSR_LOG2-1:0] LAST_SLOW = OSR_LOG2'((1 << OSR_LOG2) - 1);
  localparam logic [OSR_LOG2-1:0] LAST_FAST = OSR_LOG2'((1 << (OSR_LOG2 - 1)) - 1);

  logic [OSR_LOG2-1:0] pre;
  logic [OSR_LOG2-1:0] last;

  assign last = hs_sel ? LAST_FAST : LAST_SLOW;

  always_ff @(posedge clk) begin
    if (!rst_n || reload) begin
      pre      <= '0;
      bit_tick <= 1'b0;
    end else if (os_tick) begin
      if (pre >= last) begin
        pre      <= '0;
        bit_tick <= 1'b1;
      end else begin
        pre      <= pre + OSR_LOG2'(1);
        bit_tick <= 1'b0;
      end
    end else begin
      bit_tick <= 1'b0;
    end
  end

  // R9: a baud tick always follows an oversample tick
  a_r9_bit_after_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> $past(os_tick));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hs_sel,
  input  logic                  int_wr,
  input  logic [DIV_INT_W-1:0]  int_din,
  input  logic                  frac_wr,
  input  logic [DIV_FRAC_W-1:0] frac_din,
  input  logic                  lcr_wr,
  input  logic [LINE_W-1:0]     lcr_din,
  output logic                  os_tick,
  output logic                  bit_tick,
  output logic [LINE_W-1:0]     line_ctrl
);
  baud_active_t active;
  logic         commit;

  baud_stage_regs u_stage (
    .clk(clk), .rst_n(rst_n),
    .int_wr(int_wr), .int_din(int_din),
    .frac_wr(frac_wr), .frac_din(frac_din),
    .lcr_wr(lcr_wr), .lcr_din(lcr_din),
    .active(active), .commit(commit)
  );

  baud_frac_div #(.INT_W(DIV_INT_W), .FRAC_W(DIV_FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .reload(commit),
    .div_whole(active.whole), .div_frac(active.frac),
    .os_tick(os_tick)
  );

  baud_bit_prescale #(.OSR_LOG2(OSR_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .reload(commit),
    .hs_sel(hs_sel), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  assign line_ctrl = active.line;

  // R1: the line-control output changes only after a commit
  a_r1_line_follows_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_wr |=> $stable(line_ctrl));
endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hs_sel = 1'b0;
  logic        int_wr = 1'b0;
  logic [15:0] int_din = '0;
  logic        frac_wr = 1'b0;
  logic [5:0]  frac_din = '0;
  logic        lcr_wr = 1'b0;
  logic [7:0]  lcr_din = '0;
  logic        os_tick, bit_tick;
  logic [7:0]  line_ctrl;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .hs_sel(hs_sel),
    .int_wr(int_wr), .int_din(int_din),
    .frac_wr(frac_wr), .frac_din(frac_din),
    .lcr_wr(lcr_wr), .lcr_din(lcr_din),
    .os_tick(os_tick), .bit_tick(bit_tick), .line_ctrl(line_ctrl)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_int(input int v);
    @(negedge clk); int_wr = 1'b1; int_din = 16'(v);
    @(negedge clk); int_wr = 1'b0;
  endtask

  task automatic wr_frac(input int v);
    @(negedge clk); frac_wr = 1'b1; frac_din = 6'(v);
    @(negedge clk); frac_wr = 1'b0;
  endtask

  // returns at the negedge right after the commit edge
  task automatic commit(input int v);
    @(negedge clk); lcr_wr = 1'b1; lcr_din = 8'(v);
    @(negedge clk); lcr_wr = 1'b0;
  endtask

  // measure n os_tick intervals: total, shortest, longest
  task automatic measure(input int n, output int sum, output int mn, output int mx);
    int c;
    sum = 0; mn = 1 << 30; mx = 0;
    do @(negedge clk); while (!os_tick);
    for (int k = 0; k < n; k++) begin
      c = 0;
      do begin @(negedge clk); c++; end while (!os_tick);
      sum += c;
      if (c < mn) mn = c;
      if (c > mx) mx = c;
    end
  endtask

  task automatic count_ticks(input int cycles, output int os_n, output int bit_n);
    os_n = 0; bit_n = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (os_tick) os_n++;
      if (bit_tick) bit_n++;
    end
  endtask

  task automatic t_reset();
    int o, b;
    check("R1 line_ctrl after reset", line_ctrl, 0);
    count_ticks(100, o, b);
    check("R1 os ticks before commit", o, 0);
    check("R8 bit ticks before commit", b, 0);
  endtask

  task automatic t_integer();
    int s, mn, mx;
    wr_int(3); wr_frac(0); commit(8'h13);
    check("R3 line_ctrl after commit", line_ctrl, 8'h13);
    measure(20, s, mn, mx);
    check("R7 shortest I=3", mn, 3);
    check("R7 longest I=3", mx, 3);
  endtask

  task automatic t_stage_only();
    int s, mn, mx;
    wr_int(9); wr_frac(5);
    measure(8, s, mn, mx);
    check("R2 staged writes ignored (total)", s, 24);
    check("R2 line_ctrl unchanged", line_ctrl, 8'h13);
    commit(8'h2a);
    check("R3 new line byte", line_ctrl, 8'h2a);
    measure(64, s, mn, mx);
    check("R3 committed 9+5/64 total", s, 64 * 9 + 5);
  endtask

  task automatic t_fraction();
    int s, mn, mx;
    wr_int(3); wr_frac(16); commit(8'h01);
    measure(64, s, mn, mx);
    check("R6 total 3+16/64", s, 64 * 3 + 16);
    check("R6 shortest", mn, 3);
    check("R6 longest", mx, 4);
  endtask

  task automatic t_order();
    int s1, s2, mn, mx;
    wr_frac(40); wr_int(6); commit(8'h05);
    measure(64, s1, mn, mx);
    wr_int(2); wr_frac(1); commit(8'h05);
    wr_int(6); wr_frac(40); commit(8'h05);
    measure(64, s2, mn, mx);
    check("R4 frac-first total", s1, 64 * 6 + 40);
    check("R4 int-first total", s2, 64 * 6 + 40);
  endtask

  task automatic t_partial();
    int s, mn, mx;
    wr_int(5); wr_frac(8); commit(8'h00);
    wr_int(4); commit(8'h00);
    measure(64, s, mn, mx);
    check("R5 fraction kept, total 4+8/64", s, 64 * 4 + 8);
    wr_frac(0); commit(8'h00);
    measure(16, s, mn, mx);
    check("R5 whole kept, shortest", mn, 4);
    check("R5 whole kept, longest", mx, 4);
  endtask

  task automatic t_first_tick();
    int j;
    wr_int(7); wr_frac(0); commit(8'h00);
    j = 0;
    do begin @(negedge clk); j++; end while (!os_tick && j < 50);
    check("R10 first tick after commit", j, 8);
    wr_int(1); commit(8'h00);
    j = 0;
    do begin @(negedge clk); j++; end while (!os_tick && j < 50);
    check("R10 first tick I=1", j, 2);
  endtask

  task automatic t_min_div();
    int s, mn, mx;
    measure(10, s, mn, mx);
    check("R6 I=1 interval", mx, 1);
  endtask

  task automatic t_zero();
    int o, b;
    wr_int(0); wr_frac(33); commit(8'h00);
    count_ticks(200, o, b);
    check("R8 os ticks with zero divisor", o, 0);
    check("R8 bit ticks with zero divisor", b, 0);
  endtask

  task automatic bit_spacing(output int c);
    do @(negedge clk); while (!bit_tick);
    c = 0;
    do begin @(negedge clk); c++; end while (!bit_tick);
  endtask

  task automatic t_bit_ticks();
    int c;
    hs_sel = 1'b0;
    wr_int(2); wr_frac(0); commit(8'h00);
    bit_spacing(c);
    check("R9 16x bit period", c, 32);
    hs_sel = 1'b1;
    bit_spacing(c);
    bit_spacing(c);
    check("R9 8x bit period", c, 16);
    hs_sel = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_integer();
    t_stage_only();
    t_fraction();
    t_order();
    t_partial();
    t_first_tick();
    t_min_div();
    t_zero();
    t_bit_ticks();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule